// File: doc/BRIEF.md
# Dual Compare Timer with Privileged Interrupt Override

This block is a per-core timer unit with two compare channels: a physical one and a virtual one. Both channels watch one shared free-running 64-bit count that arrives on an input. Each channel holds a 64-bit compare value and a small control word with enable, mask and status fields. It raises one level-sensitive interrupt line while its status is set and its own mask is clear. The physical channel compares the raw count. The virtual channel first subtracts a programmable 64-bit offset.

A hypervisor control register holds one override bit per channel. While the core runs in either of the two highest-privilege security states, a set override bit forces that channel's interrupt low, whatever the channel's own mask says. In the other two states the override bits have no effect. The interrupt outputs are registered and are recomputed on every clock edge. A change of the security-state input therefore takes effect on the next edge, without any register write.

Software reaches the registers through a plain synchronous write port and a combinational read port. Both ports use the same 4-bit address space. The count and the security state are plain level inputs with no handshake: the block samples them on every cycle.

Top module: `dual_cmp_timer`

## Requirements
- R1: Reset clears both compare values, both control words and the virtual offset. It sets the hypervisor control register to 3 and drives both interrupt outputs low.
- R2: A channel's status is 1 when the channel is enabled and (count − offset) ≥ compare, with the subtraction and the comparison both unsigned modulo 2^64. The physical channel uses an offset of zero. The virtual channel uses the offset register, so a count below the offset wraps to a large value.
- R3: While a channel's enable bit is 0, its status reads 0 and its interrupt output is low.
- R4: Each interrupt output equals status AND NOT mask, sampled at a clock edge, unless the override of R6 applies. It therefore changes on the first rising edge after the change in any input or register that caused it.
- R5: The control word uses bit 0 for enable, bit 1 for mask and bit 2 for status. Bit 2 reads the live status, and writes to it are ignored. Bits 63..3 read 0.
- R6: Bit 18 of the hypervisor control register forces the virtual interrupt low, and bit 19 forces the physical interrupt low. Each does so only while the security state is Root (2) or Realm (3).
- R7: In Secure (0) and Non-secure (1) states both override bits are ignored, and the interrupts follow R4.
- R8: A change of the security-state input alone updates both interrupt outputs on the next rising edge.
- R9: The register addresses are: 0 physical compare, 1 physical control, 2 virtual compare, 3 virtual control, 4 virtual offset, 5 hypervisor control. The hypervisor control register is 32 bits wide, and its upper 32 read bits are 0. Writes to addresses 6 to 15 change nothing, and reads there return 0.
- R10: Changing only a channel's mask bit moves the interrupt output on the next edge, based on the existing status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 64 | Combinational read data |
| count_in | input | 64 | Shared free-running count |
| sec_state | input | 2 | Security state: 0 Secure, 1 Non-secure, 2 Root, 3 Realm |
| irq_phys | output | 1 | Physical channel interrupt (level) |
| irq_virt | output | 1 | Virtual channel interrupt (level) |

## Verification
Each interrupt output is due exactly one rising edge after the count, security state, or register write that decides it. The bench therefore computes the expected level from its model before the edge, using the old register contents and the current inputs. It applies the write to the model only after that, and compares the output just after the edge. Read data is combinational, so it is checked in the same cycle: after the edge that commits any write, against the updated model and the unchanged count. Directed cases pin down the one-edge lag on mask toggles and security-state changes. They also pin down the wrap of the virtual subtraction.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  typedef enum logic [1:0] {
    SEC_SECURE = 2'd0,
    SEC_NONSEC = 2'd1,
    SEC_ROOT   = 2'd2,
    SEC_REALM  = 2'd3
  } sec_state_e;

  localparam int NUM_CH  = 2;
  localparam int CH_PHYS = 0;
  localparam int CH_VIRT = 1;

  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;

  // Per channel i: compare at 2*i, control at 2*i+1
  localparam logic [3:0] ADDR_VOFF = 4'd4;
  localparam logic [3:0] ADDR_HYP  = 4'd5;

  function automatic logic sec_is_privileged(input logic [1:0] s);
    return (s == SEC_ROOT) || (s == SEC_REALM);
  endfunction
endpackage

// File: rtl/gtimer_channel.sv
module gtimer_channel #(
  parameter int CNT_W      = 64,
  parameter bit USE_OFFSET = 1'b0
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             en_i,
  output logic             status_o
);
  logic [CNT_W-1:0] eff_off;
  logic [CNT_W-1:0] delta;

  always_comb begin
    eff_off  = USE_OFFSET ? offset_i : '0;
    delta    = count_i - eff_off;          // modulo 2^CNT_W
    status_o = en_i && (delta >= cmp_i);   // unsigned compare
  end
endmodule

// File: rtl/gtimer_regs.sv
module gtimer_regs
  import gtimer_pkg::*;
#(
  parameter int              CNT_W   = 64,
  parameter int              HYP_W   = 32,
  parameter logic [HYP_W-1:0] HYP_RST = 32'd3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [3:0]              wr_addr,
  input  logic [CNT_W-1:0]        wr_data,
  input  logic [3:0]              rd_addr,
  output logic [CNT_W-1:0]        rd_data,
  input  logic [NUM_CH-1:0]       status_i,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmp_o,
  output logic [NUM_CH-1:0]       en_o,
  output logic [NUM_CH-1:0]       mask_o,
  output logic [CNT_W-1:0]        voff_o,
  output logic [HYP_W-1:0]        hyp_o
);
  localparam int CTL_PAD = CNT_W - 3;
  localparam int HYP_PAD = CNT_W - HYP_W;

  logic [CNT_W-1:0] voff_q;
  logic [HYP_W-1:0] hyp_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [3:0] A_CMP = 4'(2 * i);
    localparam logic [3:0] A_CTL = 4'(2 * i + 1);
    logic [CNT_W-1:0] cmp_q;
    logic             en_q;
    logic             mask_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q  <= '0;
        en_q   <= 1'b0;
        mask_q <= 1'b0;
      end else if (wr_en) begin
        if (wr_addr == A_CMP) cmp_q <= wr_data;
        if (wr_addr == A_CTL) begin
          en_q   <= wr_data[CTL_EN];
          mask_q <= wr_data[CTL_MASK];
        end
      end
    end

    assign cmp_o[i]  = cmp_q;
    assign en_o[i]   = en_q;
    assign mask_o[i] = mask_q;

    // R5: control write captures enable and mask on the next edge
    p_ctl_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTL) |=>
        (en_o[i] == $past(wr_data[CTL_EN]) && mask_o[i] == $past(wr_data[CTL_MASK])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      voff_q <= '0;
      hyp_q  <= HYP_RST;
    end else if (wr_en) begin
      if (wr_addr == ADDR_VOFF) voff_q <= wr_data;
      if (wr_addr == ADDR_HYP)  hyp_q  <= wr_data[HYP_W-1:0];
    end
  end

  assign voff_o = voff_q;
  assign hyp_o  = hyp_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      4'd0:      rd_data = cmp_o[CH_PHYS];
      4'd1:      rd_data = {{CTL_PAD{1'b0}}, status_i[CH_PHYS], mask_o[CH_PHYS], en_o[CH_PHYS]};
      4'd2:      rd_data = cmp_o[CH_VIRT];
      4'd3:      rd_data = {{CTL_PAD{1'b0}}, status_i[CH_VIRT], mask_o[CH_VIRT], en_o[CH_VIRT]};
      ADDR_VOFF: rd_data = voff_q;
      ADDR_HYP:  rd_data = {{HYP_PAD{1'b0}}, hyp_q};
      default:   rd_data = '0;
    endcase
  end

  // R9: hypervisor control only moves on a write to its own address
  p_hyp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_HYP) |=> $stable(hyp_o));
endmodule

// File: rtl/gtimer_irq_gate.sv
module gtimer_irq_gate
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] status_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] ovr_i,
  input  logic [1:0]        sec_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic priv;
  assign priv = sec_is_privileged(sec_i);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_gate
    logic irq_q;
    always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= status_i[i] && !mask_i[i] && !(ovr_i[i] && priv);
    end
    assign irq_o[i] = irq_q;

    // R6: override in Root/Realm forces the line low at the next edge
    p_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (priv && ovr_i[i]) |=> !irq_o[i]);
    // R7: in Secure/Non-secure an unmasked status raises the line
    p_nonpriv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!priv && status_i[i] && !mask_i[i]) |=> irq_o[i]);
    // R10: a set channel mask keeps the line low
    p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mask_i[i] |=> !irq_o[i]);
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import gtimer_pkg::*;
#(
  parameter int              CNT_W     = 64,
  parameter int              HYP_W     = 32,
  parameter logic [HYP_W-1:0] HYP_RST   = 32'd3,
  parameter int              VMASK_BIT = 18,
  parameter int              PMASK_BIT = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [3:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [CNT_W-1:0] count_in,
  input  logic [1:0]       sec_state,
  output logic             irq_phys,
  output logic             irq_virt
);
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  logic [NUM_CH-1:0]            en;
  logic [NUM_CH-1:0]            mask;
  logic [NUM_CH-1:0]            status;
  logic [NUM_CH-1:0]            ovr;
  logic [NUM_CH-1:0]            irq;
  logic [CNT_W-1:0]             voff;
  logic [HYP_W-1:0]             hyp;

  gtimer_regs #(.CNT_W(CNT_W), .HYP_W(HYP_W), .HYP_RST(HYP_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .status_i(status), .cmp_o(cmp), .en_o(en), .mask_o(mask),
    .voff_o(voff), .hyp_o(hyp)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    gtimer_channel #(.CNT_W(CNT_W), .USE_OFFSET(i == CH_VIRT)) u_chan (
      .count_i(count_in), .offset_i(voff), .cmp_i(cmp[i]),
      .en_i(en[i]), .status_o(status[i])
    );

    // R3: a disabled channel has its line low after the next edge
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> !irq[i]);
  end

  assign ovr[CH_PHYS] = hyp[PMASK_BIT];
  assign ovr[CH_VIRT] = hyp[VMASK_BIT];

  gtimer_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .status_i(status), .mask_i(mask), .ovr_i(ovr),
    .sec_i(sec_state), .irq_o(irq)
  );

  assign irq_phys = irq[CH_PHYS];
  assign irq_virt = irq[CH_VIRT];
endmodule

// File: tb/sim_dual_cmp_timer.sv
module sim_dual_cmp_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic [63:0] count_in = '0;
  logic [1:0]  sec_state = '0;
  logic        irq_phys, irq_virt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_cmp [2];
  logic        m_en  [2];
  logic        m_mask[2];
  logic [63:0] m_voff;
  logic [31:0] m_hyp;

  always #(CLK_P/2) clk = ~clk;

  dual_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count_in(count_in),
    .sec_state(sec_state), .irq_phys(irq_phys), .irq_virt(irq_virt)
  );

  function automatic logic f_stat(int ch, logic [63:0] cnt);
    logic [63:0] off = (ch == 1) ? m_voff : 64'd0;
    return m_en[ch] && ((cnt - off) >= m_cmp[ch]);
  endfunction

  function automatic logic f_irq(int ch, logic [63:0] cnt, logic [1:0] s);
    logic ov = (ch == 1) ? m_hyp[18] : m_hyp[19];
    return f_stat(ch, cnt) && !m_mask[ch] && !(ov && s >= 2'd2);
  endfunction

  function automatic logic [63:0] f_read(logic [3:0] a, logic [63:0] cnt);
    case (a)
      4'd0: return m_cmp[0];
      4'd1: return {61'd0, f_stat(0, cnt), m_mask[0], m_en[0]};
      4'd2: return m_cmp[1];
      4'd3: return {61'd0, f_stat(1, cnt), m_mask[1], m_en[1]};
      4'd4: return m_voff;
      4'd5: return {32'd0, m_hyp};
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cmp[c] = '0; m_en[c] = 1'b0; m_mask[c] = 1'b0;
    end
    m_voff = '0;
    m_hyp  = 32'd3;
  endtask

  // One clock: expected irq from pre-edge state, then commit write in model
  task automatic cycle();
    logic e0 = f_irq(0, count_in, sec_state);
    logic e1 = f_irq(1, count_in, sec_state);
    if (wr_en) begin
      case (wr_addr)
        4'd0: m_cmp[0] = wr_data;
        4'd1: begin m_en[0] = wr_data[0]; m_mask[0] = wr_data[1]; end
        4'd2: m_cmp[1] = wr_data;
        4'd3: begin m_en[1] = wr_data[0]; m_mask[1] = wr_data[1]; end
        4'd4: m_voff = wr_data;
        4'd5: m_hyp = wr_data[31:0];
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    chk("R4 R6 irq_phys", {63'd0, irq_phys}, {63'd0, e0});
    chk("R4 R6 irq_virt", {63'd0, irq_virt}, {63'd0, e1});
    chk("R9 rd_data", rd_data, f_read(rd_addr, count_in));
  endtask

  task automatic wr(logic [3:0] a, logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
  endtask

  task automatic idle();
    cycle();
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [63:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20231));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 irq_phys", {63'd0, irq_phys}, 64'd0);
    chk("R1 irq_virt", {63'd0, irq_virt}, 64'd0);
    rst_n = 1'b1;
    rd_chk("R1 hyp reset", 4'd5, 64'd3);
    rd_chk("R1 pctl reset", 4'd1, 64'd0);
    rd_chk("R1 voff reset", 4'd4, 64'd0);

    // R2/R4: physical compare crossing
    wr(4'd0, 64'd100);
    wr(4'd1, 64'd1);
    count_in = 64'd99; idle();
    chk("R2 below compare", {63'd0, irq_phys}, 64'd0);
    count_in = 64'd100;
    rd_chk("R5 live status", 4'd1, 64'd5);
    idle();
    chk("R4 irq after one edge", {63'd0, irq_phys}, 64'd1);

    // R10: mask toggle, one-edge lag
    wr(4'd1, 64'd3);
    chk("R10 still high at write edge", {63'd0, irq_phys}, 64'd1);
    idle();
    chk("R10 masked", {63'd0, irq_phys}, 64'd0);
    wr(4'd1, 64'd1); idle();
    chk("R10 unmasked", {63'd0, irq_phys}, 64'd1);

    // R5/R3: status bit write ignored, disabled is quiet
    wr(4'd1, 64'hFFFF_FFFF_FFFF_FFF4);
    idle();
    rd_chk("R5 status write ignored", 4'd1, 64'd0);
    chk("R3 disabled irq low", {63'd0, irq_phys}, 64'd0);

    // R2: virtual offset and wrap
    wr(4'd4, 64'd200);
    wr(4'd2, 64'd5);
    wr(4'd3, 64'd1);
    count_in = 64'd100; idle(); idle();
    chk("R2 virt wrap high", {63'd0, irq_virt}, 64'd1);
    count_in = 64'd204; idle();
    chk("R2 virt below", {63'd0, irq_virt}, 64'd0);
    count_in = 64'd205; idle();
    chk("R2 virt equal", {63'd0, irq_virt}, 64'd1);

    // R6/R7/R8: override per security state
    wr(4'd1, 64'd1);
    wr(4'd5, 64'h000C_0003);
    sec_state = 2'd0; idle();
    chk("R7 secure ignores virt ovr", {63'd0, irq_virt}, 64'd1);
    chk("R7 secure ignores phys ovr", {63'd0, irq_phys}, 64'd1);
    sec_state = 2'd3; idle();
    chk("R8 realm virt low", {63'd0, irq_virt}, 64'd0);
    chk("R6 realm phys low", {63'd0, irq_phys}, 64'd0);
    sec_state = 2'd1; idle();
    chk("R8 nonsecure virt back", {63'd0, irq_virt}, 64'd1);
    wr(4'd5, 64'h0004_0000);
    sec_state = 2'd2; idle();
    chk("R6 root virt only", {63'd0, irq_virt}, 64'd0);
    chk("R6 root phys unaffected", {63'd0, irq_phys}, 64'd1);

    // R9: unmapped addresses and hyp width
    wr(4'd9, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R9 unmapped read", 4'd9, 64'd0);
    rd_chk("R9 voff untouched", 4'd4, 64'd200);
    wr(4'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R9 hyp width", 4'd5, 64'h0000_0000_FFFF_FFFF);

    // Random phase
    for (int n = 0; n < 600; n++) begin
      int ch = $urandom_range(0, 1);
      sec_state = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0)
        count_in = {$urandom, $urandom};
      else
        count_in = m_cmp[ch] + (ch == 1 ? m_voff : 64'd0) + 64'($urandom_range(0, 4)) - 64'd2;
      rd_addr = 4'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) begin
        logic [3:0] a = 4'($urandom_range(0, 7));
        logic [63:0] d;
        if (a == 4'd1 || a == 4'd3)      d = 64'($urandom_range(0, 7));
        else if (a == 4'd5)              d = 64'({$urandom_range(0, 3), 18'd0} | 64'd3);
        else if (a == 4'd4)              d = 64'($urandom_range(0, 500));
        else                             d = {$urandom, $urandom};
        wr(a, d);
      end else begin
        idle();
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule